// File: doc/BRIEF.md
# Byte-Masked Register Bank for a Flow-Free Register Bus

This block is a small bank of control and status registers that hangs off a register bus with no backpressure of any kind, the sort of bus a memory-mapped bridge produces on its far side. A write is a one-cycle event that carries an address, data and a per-byte keep mask, and the bank takes it in that same cycle. A read is a one-cycle pulse that carries an address. The bank answers it later with a one-cycle response strobe and the data, after a fixed latency set by a parameter.

Word 0 of the bank is a read-only status word that shows an input port. Words 1 to NUM_REGS are read/write registers. Any word above that is unmapped. Register selection uses only the word part of the address, and the byte-offset bits are ignored. The requester gives up on a read that is not answered within 2^T − 1 cycles for its own timeout exponent T, so RD_LAT must be at least 1 and must stay below that bound.

Top module: `simple_reg_bank`

## Requirements
- R1: A write request is taken in the cycle it is presented, with no stall. A read issued in the next cycle returns the written data.
- R2: Byte lane b (bits 8b+7..8b) of a register changes on a write only when wr_keep[b] is 1. A write with an all-zero keep changes nothing.
- R3: Each read request produces rd_resp high for exactly one cycle, RD_LAT cycles after the request cycle. At no other time is rd_resp high.
- R4: Read requests on back-to-back cycles each receive their own response, in request order, on consecutive cycles.
- R5: The word index is addr[ADDR_W-1:log2(DATA_W/8)]. The low byte-offset bits have no effect on which register is selected.
- R6: Reading word 0 returns status_in as sampled in the request cycle. A write to word 0 changes no register.
- R7: Reading a word above NUM_REGS returns all ones with a normal response strobe. A write to such a word changes no register.
- R8: A synchronous active-high rst clears every read/write register to zero and cancels every read response still in flight.
- R9: rd_data is zero in every cycle in which rd_resp is low.
- R10: A read presented in the same cycle as a write to the same register returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| wr_keep | input | DATA_W/8 | Per-byte write enable |
| rd_req | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_resp | output | 1 | One-cycle read response strobe |
| rd_data | output | DATA_W | Read data, valid while rd_resp is high |
| status_in | input | DATA_W | Value presented at word 0 |

## Verification
A read presented in cycle c is due as a response in cycle c+RD_LAT. A write presented in cycle c is visible to a read presented in cycle c+1. The bench keeps a ring of expected responses indexed by cycle number. At the falling edge of each cycle it compares rd_resp and rd_data against the slot for that cycle, and an empty slot means the strobe and the data must both be low. A reset clears every slot after the current one, so a response that was cancelled counts as an error if it still appears.

// File: rtl/simple_reg_bank.sv
module simple_reg_bank #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int RD_LAT   = 2
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_req,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W/8-1:0] wr_keep,
  input  logic                rd_req,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                rd_resp,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [DATA_W-1:0]   status_in
);
  localparam int BYTES  = DATA_W / 8;
  localparam int LSB    = $clog2(BYTES);
  localparam int WORD_W = ADDR_W - LSB;
  localparam int CNT_W  = $clog2(RD_LAT + 2);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] pipe_d [RD_LAT];
  logic [RD_LAT-1:0] pipe_v;
  logic [DATA_W-1:0] rd_word_val;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic              unused_low;

  assign wr_word    = wr_addr[ADDR_W-1:LSB];
  assign rd_word    = rd_addr[ADDR_W-1:LSB];
  assign unused_low = ^{wr_addr[LSB-1:0], rd_addr[LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_req) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_word == WORD_W'(i + 1))
          for (int b = 0; b < BYTES; b++)
            if (wr_keep[b]) regs[i][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  always_comb begin
    rd_word_val = '1;
    if (rd_word == '0) rd_word_val = status_in;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_word == WORD_W'(i + 1)) rd_word_val = regs[i];
  end

  always_ff @(posedge clk) begin
    if (rst) pipe_v <= '0;
    else begin
      pipe_v[0] <= rd_req;
      for (int i = 1; i < RD_LAT; i++) pipe_v[i] <= pipe_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    pipe_d[0] <= rd_word_val;
    for (int i = 1; i < RD_LAT; i++) pipe_d[i] <= pipe_d[i-1];
  end

  assign rd_resp = pipe_v[RD_LAT-1];
  assign rd_data = rd_resp ? pipe_d[RD_LAT-1] : '0;

  // Checker state: reads accepted but not yet answered.
  logic [CNT_W-1:0] chk_inflight;
  always_ff @(posedge clk) begin
    if (rst) chk_inflight <= '0;
    else chk_inflight <= chk_inflight + CNT_W'(rd_req) - CNT_W'(rd_resp);
  end

  a_r3_resp_has_request: assert property (@(posedge clk) disable iff (rst)
    rd_resp |-> chk_inflight != '0);
  a_r4_inflight_bound: assert property (@(posedge clk) disable iff (rst)
    chk_inflight <= CNT_W'(RD_LAT));
  a_r6_status_capture: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_word == '0 |=> pipe_d[0] == $past(status_in));
  a_r7_unmapped_read: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_word > WORD_W'(NUM_REGS) |=> pipe_d[0] == '1);
  a_r8_reset_cancels: assert property (@(posedge clk)
    rst |=> !rd_resp);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
    a_r2_no_keep_no_change: assert property (@(posedge clk) disable iff (rst)
      wr_req && wr_keep == '0 |=> regs[g] == $past(regs[g]));
    a_r7_unmapped_write: assert property (@(posedge clk) disable iff (rst)
      wr_req && wr_word > WORD_W'(NUM_REGS) |=> regs[g] == $past(regs[g]));
    a_r6_status_write: assert property (@(posedge clk) disable iff (rst)
      wr_req && wr_word == '0 |=> regs[g] == $past(regs[g]));
  end
endmodule

// File: tb/simple_reg_bank_tb.sv
module simple_reg_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, AW = 16, NR = 4, LAT = 2;

  logic clk = 0, rst = 1;
  logic wr_req = 0, rd_req = 0, rd_resp;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data, status_in = '0;
  logic [3:0] wr_keep = '0;

  simple_reg_bank #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR), .RD_LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_keep(wr_keep), .rd_req(rd_req), .rd_addr(rd_addr), .rd_resp(rd_resp),
    .rd_data(rd_data), .status_in(status_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] mem [NR];
  bit exp_v [16];
  logic [DW-1:0] exp_d [16];
  string exp_tag [16];

  function automatic logic [DW-1:0] model_read(int w, logic [DW-1:0] st);
    if (w == 0) return st;
    if (w <= NR) return mem[w-1];
    return '1;
  endfunction

  function automatic logic [AW-1:0] mk_addr(int w, int low);
    return AW'(w * 4 + low);
  endfunction

  task automatic step(bit r, bit w, int ww, int wl, logic [DW-1:0] wd, logic [3:0] wk,
                      bit rd, int rw, int rl, logic [DW-1:0] st, string tag);
    int s;
    @(negedge clk);
    s = cyc % 16;
    checks++;
    if (exp_v[s]) begin
      if (rd_resp !== 1'b1 || rd_data !== exp_d[s]) begin
        fails++;
        $display("FAIL %s: resp=%b data=%h expected resp=1 data=%h", exp_tag[s], rd_resp, rd_data, exp_d[s]);
      end
    end else if (rd_resp !== 1'b0 || rd_data !== '0) begin
      fails++;
      $display("FAIL R3/R9: resp=%b data=%h expected resp=0 data=0", rd_resp, rd_data);
    end
    exp_v[s] = 0;
    rst = r; wr_req = w; wr_addr = mk_addr(ww, wl); wr_data = wd; wr_keep = wk;
    rd_req = rd; rd_addr = mk_addr(rw, rl); status_in = st;
    if (r) begin
      for (int i = 0; i < NR; i++) mem[i] = '0;
      for (int i = 0; i < 16; i++) exp_v[i] = 0;
    end else begin
      if (rd) begin
        exp_v[(cyc + LAT) % 16] = 1;
        exp_d[(cyc + LAT) % 16] = model_read(rw, st);
        exp_tag[(cyc + LAT) % 16] = tag;
      end
      if (w && ww >= 1 && ww <= NR)
        for (int b = 0; b < 4; b++) if (wk[b]) mem[ww-1][8*b +: 8] = wd[8*b +: 8];
    end
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, '0, 0, 0, 0, 32'h5A5A_0000, "");
  endtask

  task automatic rd(int w, int low, logic [DW-1:0] st, string tag);
    step(0, 0, 0, 0, '0, '0, 1, w, low, st, tag);
  endtask

  task automatic wr(int w, int low, logic [DW-1:0] d, logic [3:0] k);
    step(0, 1, w, low, d, k, 0, 0, 0, '0, "");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    for (int i = 0; i < NR; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) exp_v[i] = 0;
    repeat (3) @(negedge clk);
    step(1, 0, 0, 0, '0, '0, 0, 0, 0, '0, "");
    step(0, 0, 0, 0, '0, '0, 0, 0, 0, '0, "");
    // R8: registers read zero after reset; R6: status word
    for (int w = 0; w <= NR; w++) rd(w, 0, 32'hC0DE_0000 + w, w == 0 ? "R6" : "R8");
    idle(LAT);
    // R1: write then read next cycle
    wr(1, 0, 32'hDEAD_BEEF, 4'hF);
    rd(1, 0, '0, "R1");
    // R2: partial keep and empty keep
    wr(2, 0, 32'h1111_1111, 4'hF);
    wr(2, 0, 32'hAABB_CCDD, 4'b0101);
    rd(2, 0, '0, "R2");
    wr(2, 0, 32'hFFFF_FFFF, 4'b0000);
    rd(2, 0, '0, "R2");
    // R10: read and write to same register in one cycle
    step(0, 1, 3, 0, 32'h0BAD_F00D, 4'hF, 1, 3, 0, '0, "R10");
    rd(3, 0, '0, "R10");
    // R6/R7: writes to status and unmapped words leave registers unchanged
    wr(0, 0, 32'h7777_7777, 4'hF);
    wr(NR + 3, 0, 32'h6666_6666, 4'hF);
    for (int w = 1; w <= NR; w++) rd(w, 0, '0, "R7");
    rd(NR + 1, 0, '0, "R7");
    // R5: byte-offset bits ignored
    wr(4, 3, 32'h4444_0004, 4'hF);
    rd(4, 2, '0, "R5");
    // R4: back-to-back reads, in order
    rd(1, 0, '0, "R4"); rd(0, 0, 32'h0000_0042, "R4"); rd(3, 1, '0, "R4"); rd(9, 0, '0, "R4");
    idle(LAT + 1);
    // R8: reset cancels in-flight read
    rd(1, 0, '0, "R8");
    step(1, 0, 0, 0, '0, '0, 0, 0, 0, '0, "");
    step(0, 0, 0, 0, '0, '0, 0, 0, 0, '0, "");
    rd(1, 0, '0, "R8");
    idle(LAT);
    // Random mix
    for (int n = 0; n < 400; n++) begin
      bit dw, dr;
      dw = ($urandom_range(0, 2) == 0);
      dr = ($urandom_range(0, 1) == 0);
      step(0, dw, $urandom_range(0, NR + 2), $urandom_range(0, 3), $urandom, 4'($urandom_range(0, 15)),
           dr, $urandom_range(0, NR + 2), $urandom_range(0, 3), $urandom, "R4");
    end
    idle(LAT + 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule